// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block computes a line-and-bit parity code over one flash sector while the sector's 16-bit words stream through it, one word per accepted cycle. A sector is 256 main-area words followed by the two protected spare words, 258 stream positions in all. Separate accumulators keep a 24-bit code for the main area and a 10-bit code for the two spare words. Each code is a set of even/odd parity pairs, one pair for each bit of the word position and one pair for each bit of the bit position.

In program mode the engine hands out both computed codes with a write strobe, so they can be placed in the spare area. In load mode the host supplies the codes that were stored at program time along with the `sector_done` strobe. The engine forms a syndrome for each area and classifies it. It then reports a clean sector, one correctable bit (with its stream position, bit position and a one-hot flip mask for the buffer write-back), or an uncorrectable error. It passes the stored codes, not the recomputed ones, back out for the buffer spare area.

A bypass input, sampled at `sector_start`, turns all of this off. In bypass, nothing accumulates, no code write is requested, no correction is offered and the status reads invalid.

Top module: `sector_ecc_engine`

## Requirements
- R1: In program mode, main_code_o bit k (k=0..7) is the XOR of every data bit of main words whose position has bit k clear. Bit 8+k is the same with bit k set. Bit 16+j (j=0..3) is the XOR of data bits, over all main words, whose bit position has bit j clear. Bit 20+j is the same with bit j set.
- R2: spare_code_o uses the same rule over the two spare words, stream positions 256 and 257 taken as spare index 0 and 1. Bit 0 is spare index 0 and bit 1 is index 1. Bits 2..5 hold bit positions with bit j clear, and bits 6..9 hold those with bit j set.
- R3: done_o is a one-cycle pulse in the cycle after sector_done_i. In program mode without bypass, code_wr_o is 1 with it, status_o is 00 and flip_mask_o is 0.
- R4: In load mode, main_code_o and spare_code_o equal stored_main_i and stored_spare_i as sampled with sector_done_i.
- R5: In load mode, a single flipped data bit gives status 01. err_word_o gives its stream position (0..257), err_bit_o its bit position, and flip_mask_o has only that bit set.
- R6: In load mode, a syndrome with exactly one bit set (an error in a stored code) gives status 01 with flip_mask_o, err_word_o and err_bit_o all 0.
- R7: In load mode, any two bit errors give status 10 and flip_mask_o 0. This holds in the same word, in two words, with one in main and one in spare, or with one in data and one in a code.
- R8: In load mode with matching codes, status is 00 and flip_mask_o is 0.
- R9: With bypass in load mode, status is 11 and flip_mask_o is 0, whatever the errors, and the stored codes are still forwarded.
- R10: With bypass in program mode, code_wr_o stays 0, both code outputs are 0 and status is 11.
- R11: sector_start_i clears both accumulators, so a sector that was abandoned part-way leaves no trace in the next.
- R12: Words offered after the 258th of a sector do not change the codes.
- R13: After reset, done_o, code_wr_o, status_o, flip_mask_o and both code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_start_i | input | 1 | Begins a sector, clears parities, samples mode and bypass |
| prog_mode_i | input | 1 | 1 = program, 0 = load |
| bypass_i | input | 1 | Disables generation and correction for the sector |
| word_valid_i | input | 1 | word_i carries the next sector word |
| word_i | input | 16 | Sector data word |
| sector_done_i | input | 1 | End of sector, samples the stored codes |
| stored_main_i | input | 24 | Main code read from the spare area |
| stored_spare_i | input | 10 | Spare code read from the spare area |
| done_o | output | 1 | Results valid pulse |
| status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 invalid |
| err_word_o | output | 9 | Stream position of the corrected bit |
| err_bit_o | output | 4 | Bit position of the corrected bit |
| flip_mask_o | output | 16 | One-hot mask to XOR into the faulty word |
| main_code_o | output | 24 | Main code to write (program) or stored code (load) |
| spare_code_o | output | 10 | Spare code to write (program) or stored code (load) |
| code_wr_o | output | 1 | Codes should be written to the spare area |

## Verification
The assertions assume three things about the inputs. sector_done_i is a single-cycle strobe with no word in the same cycle. Each sector is opened by sector_start_i before its words. Mode and bypass hold steady between the start and done strobes that they frame. The bench drives every sector through one task that raises the start for one cycle, streams the words on consecutive cycles and then raises done for one cycle. Errors are injected only by XOR-ing bits of the streamed copy or of the stored codes.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_FIXED   = 2'b01,
    ST_FATAL   = 2'b10,
    ST_INVALID = 2'b11
  } ecc_status_e;

  typedef enum logic [1:0] {
    CL_NONE  = 2'b00,
    CL_DATA  = 2'b01,
    CL_CODE  = 2'b10,
    CL_MULTI = 2'b11
  } syn_class_e;

endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr_i,
  input  logic                               en_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [DATA_W-1:0]                  data_i,
  output logic [2*(IDX_W+$clog2(DATA_W))-1:0] code_o
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [IDX_W-1:0] ev_w_q, od_w_q, ev_w_nx, od_w_nx, ev_w_d, od_w_d;
  logic [BIT_W-1:0] ev_b_q, od_b_q, ev_b_nx, od_b_nx, ev_b_d, od_b_d;
  logic [BIT_W-1:0][DATA_W-1:0] hi_sel;
  logic word_par;

  assign word_par = ^data_i;

  for (genvar k = 0; k < IDX_W; k++) begin : g_widx
    assign ev_w_nx[k] = ev_w_q[k] ^ (word_par & ~idx_i[k]);
    assign od_w_nx[k] = od_w_q[k] ^ (word_par &  idx_i[k]);
  end

  for (genvar j = 0; j < BIT_W; j++) begin : g_bidx
    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
      assign hi_sel[j][i] = (((i >> j) & 1) != 0);
    end
    assign od_b_nx[j] = od_b_q[j] ^ (^(data_i &  hi_sel[j]));
    assign ev_b_nx[j] = ev_b_q[j] ^ (^(data_i & ~hi_sel[j]));
  end

  always_comb begin
    ev_w_d = ev_w_q;
    od_w_d = od_w_q;
    ev_b_d = ev_b_q;
    od_b_d = od_b_q;
    if (clr_i) begin
      ev_w_d = '0;
      od_w_d = '0;
      ev_b_d = '0;
      od_b_d = '0;
    end else if (en_i) begin
      ev_w_d = ev_w_nx;
      od_w_d = od_w_nx;
      ev_b_d = ev_b_nx;
      od_b_d = od_b_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_w_q <= '0;
      od_w_q <= '0;
      ev_b_q <= '0;
      od_b_q <= '0;
    end else begin
      ev_w_q <= ev_w_d;
      od_w_q <= od_w_d;
      ev_b_q <= ev_b_d;
      od_b_q <= od_b_d;
    end
  end

  assign code_o = {od_b_q, ev_b_q, od_w_q, ev_w_q};

  a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (code_o == '0));

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(code_o));

endmodule

// File: rtl/ecc_syndrome_class.sv
module ecc_syndrome_class
  import ecc_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int BIT_W = 4
) (
  input  logic [2*(IDX_W+BIT_W)-1:0] stored_i,
  input  logic [2*(IDX_W+BIT_W)-1:0] calc_i,
  output syn_class_e                 cls_o,
  output logic [IDX_W-1:0]           word_o,
  output logic [BIT_W-1:0]           bit_o
);

  localparam int CW = 2*(IDX_W+BIT_W);

  logic [CW-1:0]    syn;
  logic [IDX_W-1:0] sw_ev, sw_od;
  logic [BIT_W-1:0] sb_ev, sb_od;
  logic             pairs_split;
  logic             one_bit;

  assign syn   = stored_i ^ calc_i;
  assign sw_ev = syn[IDX_W-1:0];
  assign sw_od = syn[2*IDX_W-1:IDX_W];
  assign sb_ev = syn[2*IDX_W+BIT_W-1:2*IDX_W];
  assign sb_od = syn[CW-1:2*IDX_W+BIT_W];

  assign pairs_split = (&(sw_ev ^ sw_od)) && (&(sb_ev ^ sb_od));
  assign one_bit     = (syn != '0) && ((syn & (syn - CW'(1))) == '0);

  always_comb begin
    cls_o  = CL_NONE;
    word_o = '0;
    bit_o  = '0;
    if (syn == '0) begin
      cls_o = CL_NONE;
    end else if (pairs_split) begin
      cls_o  = CL_DATA;
      word_o = sw_od;
      bit_o  = sb_od;
    end else if (one_bit) begin
      cls_o = CL_CODE;
    end else begin
      cls_o = CL_MULTI;
    end
  end

endmodule

// File: rtl/ecc_result_merge.sv
module ecc_result_merge
  import ecc_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int MAIN_WORDS = 256,
  parameter int MAIN_IDX_W = 8,
  parameter int SP_IDX_W   = 1,
  parameter int BIT_W      = 4,
  parameter int POS_W      = 9
) (
  input  logic                  prog_i,
  input  logic                  byp_i,
  input  syn_class_e            main_cls_i,
  input  logic [MAIN_IDX_W-1:0] main_word_i,
  input  logic [BIT_W-1:0]      main_bit_i,
  input  syn_class_e            sp_cls_i,
  input  logic [SP_IDX_W-1:0]   sp_word_i,
  input  logic [BIT_W-1:0]      sp_bit_i,
  output ecc_status_e           status_o,
  output logic [POS_W-1:0]      pos_o,
  output logic [BIT_W-1:0]      bit_o,
  output logic [WORD_W-1:0]     mask_o
);

  logic main_hit, sp_hit;

  assign main_hit = (main_cls_i != CL_NONE);
  assign sp_hit   = (sp_cls_i != CL_NONE);

  always_comb begin
    status_o = ST_CLEAN;
    pos_o    = '0;
    bit_o    = '0;
    mask_o   = '0;
    if (byp_i) begin
      status_o = ST_INVALID;
    end else if (prog_i) begin
      status_o = ST_CLEAN;
    end else if ((main_cls_i == CL_MULTI) || (sp_cls_i == CL_MULTI) ||
                 (main_hit && sp_hit)) begin
      status_o = ST_FATAL;
    end else if (main_cls_i == CL_DATA) begin
      status_o = ST_FIXED;
      pos_o    = POS_W'(main_word_i);
      bit_o    = main_bit_i;
      mask_o   = WORD_W'(1) << main_bit_i;
    end else if (sp_cls_i == CL_DATA) begin
      status_o = ST_FIXED;
      pos_o    = POS_W'(MAIN_WORDS) + POS_W'(sp_word_i);
      bit_o    = sp_bit_i;
      mask_o   = WORD_W'(1) << sp_bit_i;
    end else if (main_hit || sp_hit) begin
      status_o = ST_FIXED;
    end
  end

endmodule

// File: rtl/sector_ecc_engine.sv
module sector_ecc_engine
  import ecc_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int MAIN_WORDS  = 256,
  parameter int SPARE_WORDS = 2
) (
  input  logic                                                clk,
  input  logic                                                rst_n,
  input  logic                                                sector_start_i,
  input  logic                                                prog_mode_i,
  input  logic                                                bypass_i,
  input  logic                                                word_valid_i,
  input  logic [WORD_W-1:0]                                   word_i,
  input  logic                                                sector_done_i,
  input  logic [2*($clog2(MAIN_WORDS)+$clog2(WORD_W))-1:0]    stored_main_i,
  input  logic [2*(((SPARE_WORDS>1)?$clog2(SPARE_WORDS):1)+$clog2(WORD_W))-1:0] stored_spare_i,
  output logic                                                done_o,
  output logic [1:0]                                          status_o,
  output logic [$clog2(MAIN_WORDS+SPARE_WORDS)-1:0]           err_word_o,
  output logic [$clog2(WORD_W)-1:0]                           err_bit_o,
  output logic [WORD_W-1:0]                                   flip_mask_o,
  output logic [2*($clog2(MAIN_WORDS)+$clog2(WORD_W))-1:0]    main_code_o,
  output logic [2*(((SPARE_WORDS>1)?$clog2(SPARE_WORDS):1)+$clog2(WORD_W))-1:0] spare_code_o,
  output logic                                                code_wr_o
);

  localparam int BIT_W      = $clog2(WORD_W);
  localparam int MAIN_IDX_W = $clog2(MAIN_WORDS);
  localparam int SP_IDX_W   = (SPARE_WORDS > 1) ? $clog2(SPARE_WORDS) : 1;
  localparam int TOTAL      = MAIN_WORDS + SPARE_WORDS;
  localparam int CNT_W      = $clog2(TOTAL + 1);
  localparam int POS_W      = $clog2(TOTAL);
  localparam int MCODE_W    = 2*(MAIN_IDX_W + BIT_W);
  localparam int SCODE_W    = 2*(SP_IDX_W + BIT_W);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // sector framing state
  logic [CNT_W-1:0] cnt_q, cnt_d, sp_off;
  logic             prog_q, prog_d, byp_q, byp_d;
  logic             in_main, in_spare, main_en, sp_en;

  assign in_main  = (cnt_q < CNT_W'(MAIN_WORDS));
  assign in_spare = !in_main && (cnt_q < CNT_W'(TOTAL));
  assign main_en  = word_valid_i && !sector_start_i && !byp_q && in_main;
  assign sp_en    = word_valid_i && !sector_start_i && !byp_q && in_spare;
  assign sp_off   = cnt_q - CNT_W'(MAIN_WORDS);

  always_comb begin
    cnt_d  = cnt_q;
    prog_d = prog_q;
    byp_d  = byp_q;
    if (sector_start_i) begin
      cnt_d  = '0;
      prog_d = prog_mode_i;
      byp_d  = bypass_i;
    end else if (word_valid_i && (cnt_q < CNT_W'(TOTAL))) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      prog_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prog_q <= prog_d;
      byp_q  <= byp_d;
    end
  end

  // parity accumulators
  logic [MCODE_W-1:0] main_calc;
  logic [SCODE_W-1:0] sp_calc;

  ecc_parity_acc #(.DATA_W(WORD_W), .IDX_W(MAIN_IDX_W)) u_main_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (sector_start_i),
    .en_i   (main_en),
    .idx_i  (cnt_q[MAIN_IDX_W-1:0]),
    .data_i (word_i),
    .code_o (main_calc)
  );

  ecc_parity_acc #(.DATA_W(WORD_W), .IDX_W(SP_IDX_W)) u_spare_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (sector_start_i),
    .en_i   (sp_en),
    .idx_i  (sp_off[SP_IDX_W-1:0]),
    .data_i (word_i),
    .code_o (sp_calc)
  );

  // syndrome classification
  syn_class_e            main_cls, sp_cls;
  logic [MAIN_IDX_W-1:0] main_word;
  logic [SP_IDX_W-1:0]   sp_word;
  logic [BIT_W-1:0]      main_bit, sp_bit;

  ecc_syndrome_class #(.IDX_W(MAIN_IDX_W), .BIT_W(BIT_W)) u_main_cls (
    .stored_i (stored_main_i),
    .calc_i   (main_calc),
    .cls_o    (main_cls),
    .word_o   (main_word),
    .bit_o    (main_bit)
  );

  ecc_syndrome_class #(.IDX_W(SP_IDX_W), .BIT_W(BIT_W)) u_spare_cls (
    .stored_i (stored_spare_i),
    .calc_i   (sp_calc),
    .cls_o    (sp_cls),
    .word_o   (sp_word),
    .bit_o    (sp_bit)
  );

  ecc_status_e       st_nx;
  logic [POS_W-1:0]  pos_nx;
  logic [BIT_W-1:0]  bit_nx;
  logic [WORD_W-1:0] mask_nx;

  ecc_result_merge #(
    .WORD_W     (WORD_W),
    .MAIN_WORDS (MAIN_WORDS),
    .MAIN_IDX_W (MAIN_IDX_W),
    .SP_IDX_W   (SP_IDX_W),
    .BIT_W      (BIT_W),
    .POS_W      (POS_W)
  ) u_merge (
    .prog_i      (prog_q),
    .byp_i       (byp_q),
    .main_cls_i  (main_cls),
    .main_word_i (main_word),
    .main_bit_i  (main_bit),
    .sp_cls_i    (sp_cls),
    .sp_word_i   (sp_word),
    .sp_bit_i    (sp_bit),
    .status_o    (st_nx),
    .pos_o       (pos_nx),
    .bit_o       (bit_nx),
    .mask_o      (mask_nx)
  );

  // result registers, loaded on sector_done
  logic               done_q, wr_q, wr_d;
  ecc_status_e        st_q;
  logic [POS_W-1:0]   pos_q;
  logic [BIT_W-1:0]   bit_q;
  logic [WORD_W-1:0]  mask_q;
  logic [MCODE_W-1:0] mcode_q, mcode_d;
  logic [SCODE_W-1:0] scode_q, scode_d;

  always_comb begin
    wr_d    = 1'b0;
    mcode_d = stored_main_i;
    scode_d = stored_spare_i;
    if (prog_q) begin
      wr_d    = !byp_q;
      mcode_d = byp_q ? '0 : main_calc;
      scode_d = byp_q ? '0 : sp_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      st_q    <= ST_CLEAN;
      pos_q   <= '0;
      bit_q   <= '0;
      mask_q  <= '0;
      mcode_q <= '0;
      scode_q <= '0;
    end else begin
      done_q <= sector_done_i;
      wr_q   <= sector_done_i && wr_d;
      if (sector_done_i) begin
        st_q    <= st_nx;
        pos_q   <= pos_nx;
        bit_q   <= bit_nx;
        mask_q  <= mask_nx;
        mcode_q <= mcode_d;
        scode_q <= scode_d;
      end
    end
  end

  assign done_o      = done_q;
  assign code_wr_o   = wr_q;
  assign status_o    = st_q;
  assign err_word_o  = pos_q;
  assign err_bit_o   = bit_q;
  assign flip_mask_o = mask_q;
  assign main_code_o = mcode_q;
  assign spare_code_o = scode_q;

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !sector_done_i) |=> !done_o);

  a_r4_forward_stored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sector_done_i && !prog_q) |=>
      (main_code_o == $past(stored_main_i)) && (spare_code_o == $past(stored_spare_i)));

  a_r5_mask_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(flip_mask_o));

  a_r5_mask_needs_fix: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flip_mask_o != '0) |-> (status_o == ST_FIXED));

  a_r9_bypass_no_fix: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && byp_q) |-> ((flip_mask_o == '0) && (status_o == ST_INVALID)));

  a_r10_no_write_bypass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    code_wr_o |-> (!byp_q && prog_q && done_o));

endmodule

// File: tb/sector_ecc_engine_test.sv
`timescale 1ns/100ps
module sector_ecc_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sector_start = 1'b0, prog_mode = 1'b0, bypass = 1'b0;
  logic        word_valid = 1'b0, sector_done = 1'b0;
  logic [15:0] word = '0;
  logic [23:0] stored_main = '0;
  logic [9:0]  stored_spare = '0;
  logic        done, code_wr;
  logic [1:0]  status;
  logic [8:0]  err_word;
  logic [3:0]  err_bit;
  logic [15:0] flip_mask;
  logic [23:0] main_code;
  logic [9:0]  spare_code;

  int vectors = 0;
  int fails = 0;
  logic [15:0] mem [0:257];

  always #2.5 clk = ~clk;

  sector_ecc_engine uut (
    .clk(clk), .rst_n(rst_n), .sector_start_i(sector_start),
    .prog_mode_i(prog_mode), .bypass_i(bypass), .word_valid_i(word_valid),
    .word_i(word), .sector_done_i(sector_done), .stored_main_i(stored_main),
    .stored_spare_i(stored_spare), .done_o(done), .status_o(status),
    .err_word_o(err_word), .err_bit_o(err_bit), .flip_mask_o(flip_mask),
    .main_code_o(main_code), .spare_code_o(spare_code), .code_wr_o(code_wr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void fill(input int seed);
    for (int w = 0; w < 258; w++)
      mem[w] = 16'((w * 40503) ^ (seed * 2654435) ^ (w << 7) ^ (seed >> 3));
  endfunction

  function automatic logic [23:0] ref_main();
    logic [23:0] c = '0;
    for (int w = 0; w < 256; w++)
      for (int b = 0; b < 16; b++)
        if (mem[w][b]) begin
          for (int k = 0; k < 8; k++)
            if ((w >> k) & 1) c[8+k] = ~c[8+k]; else c[k] = ~c[k];
          for (int j = 0; j < 4; j++)
            if ((b >> j) & 1) c[20+j] = ~c[20+j]; else c[16+j] = ~c[16+j];
        end
    return c;
  endfunction

  function automatic logic [9:0] ref_spare();
    logic [9:0] c = '0;
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 16; b++)
        if (mem[256+s][b]) begin
          if (s == 1) c[1] = ~c[1]; else c[0] = ~c[0];
          for (int j = 0; j < 4; j++)
            if ((b >> j) & 1) c[6+j] = ~c[6+j]; else c[2+j] = ~c[2+j];
        end
    return c;
  endfunction

  // one sector: start, stream with optional flips, done; outputs sampled after
  task automatic run_sector(input logic prog, input logic byp,
                            input int fw1, input int fb1, input int fw2, input int fb2,
                            input logic [23:0] sm, input logic [9:0] ss, input int extra);
    @(negedge clk);
    prog_mode = prog; bypass = byp; sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    for (int w = 0; w < 258 + extra; w++) begin
      logic [15:0] fm = '0;
      if (w == fw1) fm[fb1] = ~fm[fb1];
      if (w == fw2) fm[fb2] = ~fm[fb2];
      word_valid = 1'b1;
      word = (w < 258) ? (mem[w] ^ fm) : 16'(w * 7919);
      @(negedge clk);
    end
    word_valid = 1'b0;
    sector_done = 1'b1; stored_main = sm; stored_spare = ss;
    @(negedge clk);
    sector_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 done", 32'(done), 0);
    chk("R13 status", 32'(status), 0);
    chk("R13 mask", 32'(flip_mask), 0);
    chk("R13 wr", 32'(code_wr), 0);
    chk("R13 codes", 32'({main_code, spare_code} != '0), 0);
  endtask

  task automatic t_program(input int seed);
    fill(seed);
    run_sector(1'b1, 1'b0, -1, 0, -1, 0, 24'hABCDEF, 10'h155, 0);
    chk("R1 main code", 32'(main_code), 32'(ref_main()));
    chk("R2 spare code", 32'(spare_code), 32'(ref_spare()));
    chk("R3 done", 32'(done), 1);
    chk("R3 wr", 32'(code_wr), 1);
    chk("R3 status", 32'(status), 0);
    @(negedge clk);
    chk("R3 done pulse", 32'(done), 0);
  endtask

  task automatic t_load_clean(input int seed);
    fill(seed);
    run_sector(1'b0, 1'b0, -1, 0, -1, 0, ref_main(), ref_spare(), 0);
    chk("R8 status", 32'(status), 0);
    chk("R8 mask", 32'(flip_mask), 0);
    chk("R4 main fwd", 32'(main_code), 32'(ref_main()));
    chk("R4 spare fwd", 32'(spare_code), 32'(ref_spare()));
    chk("R3 no wr on load", 32'(code_wr), 0);
  endtask

  task automatic t_single(input int seed, input int fw, input int fb);
    fill(seed);
    run_sector(1'b0, 1'b0, fw, fb, -1, 0, ref_main(), ref_spare(), 0);
    chk("R5 status", 32'(status), 1);
    chk("R5 word", 32'(err_word), 32'(fw));
    chk("R5 bit", 32'(err_bit), 32'(fb));
    chk("R5 mask", 32'(flip_mask), 32'(16'(1) << fb));
  endtask

  task automatic t_double(input int seed, input int w1, input int b1, input int w2, input int b2);
    fill(seed);
    run_sector(1'b0, 1'b0, w1, b1, w2, b2, ref_main(), ref_spare(), 0);
    chk("R7 status", 32'(status), 2);
    chk("R7 mask", 32'(flip_mask), 0);
  endtask

  task automatic t_code_err(input int seed, input logic [23:0] mflip, input logic [9:0] sflip,
                            input int fw, input logic [1:0] exp_st);
    fill(seed);
    run_sector(1'b0, 1'b0, fw, 3, -1, 0, ref_main() ^ mflip, ref_spare() ^ sflip, 0);
    chk(exp_st == 1 ? "R6 status" : "R7 data+code status", 32'(status), 32'(exp_st));
    chk(exp_st == 1 ? "R6 mask" : "R7 data+code mask", 32'(flip_mask), 0);
    if (exp_st == 1) chk("R6 word", 32'({err_word, err_bit}), 0);
  endtask

  task automatic t_bypass_load(input int seed);
    fill(seed);
    run_sector(1'b0, 1'b1, 100, 4, -1, 0, ref_main(), ref_spare(), 0);
    chk("R9 status", 32'(status), 3);
    chk("R9 mask", 32'(flip_mask), 0);
    chk("R9 fwd", 32'(main_code), 32'(ref_main()));
  endtask

  task automatic t_bypass_prog(input int seed);
    fill(seed);
    run_sector(1'b1, 1'b1, -1, 0, -1, 0, '0, '0, 0);
    chk("R10 wr", 32'(code_wr), 0);
    chk("R10 status", 32'(status), 3);
    chk("R10 codes", 32'({main_code, spare_code}), 0);
  endtask

  task automatic t_abort(input int seed);
    fill(seed + 1);
    @(negedge clk);
    prog_mode = 1'b1; bypass = 1'b0; sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    for (int w = 0; w < 40; w++) begin
      word_valid = 1'b1; word = mem[w] ^ 16'h5A5A;
      @(negedge clk);
    end
    word_valid = 1'b0;
    fill(seed);
    run_sector(1'b1, 1'b0, -1, 0, -1, 0, '0, '0, 0);
    chk("R11 main after abort", 32'(main_code), 32'(ref_main()));
    chk("R11 spare after abort", 32'(spare_code), 32'(ref_spare()));
  endtask

  task automatic t_extra(input int seed);
    fill(seed);
    run_sector(1'b1, 1'b0, -1, 0, -1, 0, '0, '0, 5);
    chk("R12 main", 32'(main_code), 32'(ref_main()));
    chk("R12 spare", 32'(spare_code), 32'(ref_spare()));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_program(1);
    t_program(77);
    t_load_clean(5);
    t_single(9, 137, 11);
    t_single(10, 0, 0);
    t_single(11, 255, 15);
    t_single(12, 256, 5);
    t_single(13, 257, 15);
    t_double(14, 10, 3, 200, 3);
    t_double(15, 50, 1, 50, 9);
    t_double(16, 30, 2, 257, 7);
    t_code_err(17, 24'h002000, 10'h000, -1, 2'd1);
    t_code_err(18, 24'h000000, 10'h080, -1, 2'd1);
    t_code_err(19, 24'h000010, 10'h000, 60, 2'd2);
    t_bypass_load(20);
    t_bypass_prog(21);
    t_abort(22);
    t_extra(23);
    finish_run();
  end

endmodule